// File: doc/BRIEF.md
# Multiplexed-Bus Target Register Read Responder

This block is the target side of a 32-bit multiplexed address/data bus, and it serves only reads. A host initiator starts a transaction by asserting `frame_n` and placing an address on `ad_i` and a command on `cbe_n`. The block decodes that address phase against a fixed base window. If the transaction is a memory read to the window, the block claims it by asserting `devsel_n_o`.

After claiming, the block waits out one turnaround clock with the AD drivers off. It then drives one 32-bit register per data phase, starting at the index given by the address and stepping up by one after each completed phase. It can stretch every phase by a programmed number of clocks with `trdy_n_o` held high.

The registers form a small internal bank that local logic fills through a load port. That port is a plain valid-qualified write with no back-pressure: every clock that has `ld_valid` high stores one word, and no ready signal exists. On the bus side, the only flow control is the bus's own pair of ready strobes. The initiator stalls with `irdy_n`, and the target stalls with `trdy_n_o`.

Top module: `mux_bus_rd_target`

## Requirements
- R1: While `rst_n` is low, `ad_oe` and `ctl_oe` are low and `devsel_n_o` and `trdy_n_o` are high. All bank entries reset to zero.
- R2: The block claims a transaction only when all three of these hold in the first clock of `frame_n` low:
  - `cbe_n` equals 4'b0110 (memory read).
  - `ad_i[1:0]` is 2'b00 (linear burst order).
  - `ad_i[31:5]` equals the base address bits 31:5.

  On a claim, `devsel_n_o` is low with `ctl_oe` high in the next clock. On any other transaction, `devsel_n_o` stays high and `ctl_oe` stays low until the bus returns idle.
- R3: In the turnaround clock after the address phase, `ad_oe` is low. `ad_oe` rises only in a clock following one in which `devsel_n_o` was already asserted.
- R4: `trdy_n_o` is low only while `devsel_n_o` is low and `ctl_oe` is high.
- R5: With a wait count of zero, the first word is driven with `trdy_n_o` low two clocks after the address-phase clock.
- R6: Once `ad_oe` is high, it stays high through the final transfer and the clock after it.
- R7: A phase completes only on a clock where `irdy_n` and `trdy_n_o` are both low. While `trdy_n_o` is low and `irdy_n` is high, `trdy_n_o` stays low and `ad_o` holds its value.
- R8: The first word comes from the index in `ad_i[4:2]` of the address phase. The index rises by one after each completed phase and wraps from the last entry to entry zero.
- R9: A `wait_cnt` value W, sampled in the address phase, holds `trdy_n_o` high for exactly W clocks at the start of every data phase.
- R10: A transfer with `frame_n` high is the last one. In the clock after it, `devsel_n_o` and `trdy_n_o` are driven high with `ctl_oe` and `ad_oe` still high. In the clock after that, all output enables are low.
- R11: A clock with `ld_valid` high stores `ld_data` at `ld_idx`, and a later read of that index returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Transaction framing strobe from the initiator, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe_n | input | 4 | Command in the address phase, byte enables afterwards |
| ad_i | input | 32 | Address/data lines as seen by the block |
| wait_cnt | input | WAIT_W | Wait clocks inserted before each data phase |
| ld_valid | input | 1 | Bank load strobe |
| ld_idx | input | IDX_W | Bank entry to load |
| ld_data | input | 32 | Word to load |
| ad_o | output | 32 | Read data driven onto AD |
| ad_oe | output | 1 | Enable for the AD drivers |
| devsel_n_o | output | 1 | Claim strobe, active low |
| trdy_n_o | output | 1 | Target ready, active low |
| ctl_oe | output | 1 | Enable for the `devsel_n_o` and `trdy_n_o` drivers |

## Verification
The assertions check the strobe ordering on every clock:
- `trdy_n_o` is never asserted without a claim.
- `ad_oe` rises only after `devsel_n_o`, and it stays high while the claim is held.
- `trdy_n_o` and `ad_o` hold while the initiator stalls.
- The final transfer is followed by one clock of driven-deasserted strobes.
- Every bank load is stored.

Only the bench scenarios can show the rest:
- The first word arrives two clocks after the address phase.
- The data sequence follows the start index and wraps.
- The exact number of wait clocks is inserted.
- A write command or an address outside the window is left unclaimed for the whole transaction.

// File: rtl/mux_bus_rd_pkg.sv
package mux_bus_rd_pkg;
  localparam logic [3:0] CMD_MEM_READ = 4'b0110;
  localparam logic [1:0] ORDER_LINEAR = 2'b00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SKIP,
    ST_TURN,
    ST_DATA,
    ST_DONE
  } rd_state_e;
endpackage

// File: rtl/mux_bus_rd_decode.sv
module mux_bus_rd_decode
  import mux_bus_rd_pkg::*;
#(
  parameter int          DW        = 32,
  parameter int          NREG      = 8,
  parameter logic [31:0] BASE_ADDR = 32'h4000_0000,
  localparam int         IDX_W     = $clog2(NREG),
  localparam int         WIN_LO    = IDX_W + 2
) (
  input  logic [DW-1:0]    ad,
  input  logic [3:0]       cmd,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  logic win_match;

  assign win_match = (ad[DW-1:WIN_LO] == BASE_ADDR[DW-1:WIN_LO]);
  assign hit       = win_match && (cmd == CMD_MEM_READ) && (ad[1:0] == ORDER_LINEAR);
  assign idx       = ad[WIN_LO-1:2];
endmodule

// File: rtl/mux_bus_rd_bank.sv
module mux_bus_rd_bank #(
  parameter int  DW    = 32,
  parameter int  NREG  = 8,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [DW-1:0]    ld_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data
);
  logic [DW-1:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)                                     mem[g] <= '0;
      else if (ld_valid && (ld_idx == IDX_W'(g)))     mem[g] <= ld_data;
    end
  end

  assign rd_data = mem[rd_idx];

  AST_LOAD_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> (mem[$past(ld_idx)] == $past(ld_data))); // R11
endmodule

// File: rtl/mux_bus_rd_seq.sv
module mux_bus_rd_seq
  import mux_bus_rd_pkg::*;
#(
  parameter int  DW     = 32,
  parameter int  NREG   = 8,
  parameter int  WAIT_W = 4,
  localparam int IDX_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              hit,
  input  logic [IDX_W-1:0]  hit_idx,
  input  logic [WAIT_W-1:0] wait_cnt,
  input  logic [DW-1:0]     rd_data,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [DW-1:0]     ad_o,
  output logic              ad_oe,
  output logic              devsel_n_o,
  output logic              trdy_n_o,
  output logic              ctl_oe
);
  rd_state_e         state;
  logic [IDX_W-1:0]  cur_idx, idx_nxt;
  logic [WAIT_W-1:0] wlat, wcnt;

  assign idx_nxt = (cur_idx == IDX_W'(NREG - 1)) ? '0 : cur_idx + 1'b1;
  assign rd_idx  = (state == ST_DATA) ? idx_nxt : cur_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur_idx    <= '0;
      wlat       <= '0;
      wcnt       <= '0;
      ad_o       <= '0;
      ad_oe      <= 1'b0;
      ctl_oe     <= 1'b0;
      devsel_n_o <= 1'b1;
      trdy_n_o   <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (!frame_n) begin
          if (hit) begin
            state      <= ST_TURN;
            cur_idx    <= hit_idx;
            wlat       <= wait_cnt;
            devsel_n_o <= 1'b0;
            ctl_oe     <= 1'b1;
          end else begin
            state <= ST_SKIP;
          end
        end
        ST_SKIP: if (frame_n && irdy_n) state <= ST_IDLE;
        ST_TURN: begin
          state    <= ST_DATA;
          ad_oe    <= 1'b1;
          ad_o     <= rd_data;
          wcnt     <= wlat;
          trdy_n_o <= (wlat != '0);
        end
        ST_DATA: begin
          if (!trdy_n_o) begin
            if (!irdy_n) begin
              if (frame_n) begin
                state      <= ST_DONE;
                devsel_n_o <= 1'b1;
                trdy_n_o   <= 1'b1;
              end else begin
                cur_idx  <= idx_nxt;
                ad_o     <= rd_data;
                wcnt     <= wlat;
                trdy_n_o <= (wlat != '0);
              end
            end
          end else begin
            wcnt     <= wcnt - 1'b1;
            trdy_n_o <= (wcnt != WAIT_W'(1));
          end
        end
        ST_DONE: begin
          state  <= ST_IDLE;
          ad_oe  <= 1'b0;
          ctl_oe <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_TRDY_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n_o |-> (!devsel_n_o && ctl_oe)); // R4
  AST_AD_AFTER_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |-> $past(!devsel_n_o && ctl_oe)); // R3
  AST_AD_KEEPS_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && !devsel_n_o) |=> ad_oe); // R6
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n_o && irdy_n) |=> (!trdy_n_o && $stable(ad_o))); // R7
  AST_FINAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n_o && !irdy_n && frame_n) |=> (devsel_n_o && trdy_n_o && ctl_oe && ad_oe)); // R10
endmodule

// File: rtl/mux_bus_rd_target.sv
module mux_bus_rd_target #(
  parameter int          DW        = 32,
  parameter int          NREG      = 8,
  parameter int          WAIT_W    = 4,
  parameter logic [31:0] BASE_ADDR = 32'h4000_0000,
  localparam int         IDX_W     = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic [3:0]        cbe_n,
  input  logic [DW-1:0]     ad_i,
  input  logic [WAIT_W-1:0] wait_cnt,
  input  logic              ld_valid,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [DW-1:0]     ld_data,
  output logic [DW-1:0]     ad_o,
  output logic              ad_oe,
  output logic              devsel_n_o,
  output logic              trdy_n_o,
  output logic              ctl_oe
);
  logic             hit;
  logic [IDX_W-1:0] hit_idx, rd_idx;
  logic [DW-1:0]    rd_data;

  mux_bus_rd_decode #(.DW(DW), .NREG(NREG), .BASE_ADDR(BASE_ADDR)) u_dec (
    .ad(ad_i), .cmd(cbe_n), .hit(hit), .idx(hit_idx)
  );

  mux_bus_rd_bank #(.DW(DW), .NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_idx(ld_idx),
    .ld_data(ld_data), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  mux_bus_rd_seq #(.DW(DW), .NREG(NREG), .WAIT_W(WAIT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .hit(hit), .hit_idx(hit_idx), .wait_cnt(wait_cnt), .rd_data(rd_data),
    .rd_idx(rd_idx), .ad_o(ad_o), .ad_oe(ad_oe), .devsel_n_o(devsel_n_o),
    .trdy_n_o(trdy_n_o), .ctl_oe(ctl_oe)
  );
endmodule

// File: tb/mux_bus_rd_target_tb.sv
module mux_bus_rd_target_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          NREG       = 8;
  localparam logic [31:0] BASE       = 32'h4000_0000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        frame_n = 1'b1, irdy_n = 1'b1;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_i = '0;
  logic [3:0]  wait_cnt = '0;
  logic        ld_valid = 1'b0;
  logic [2:0]  ld_idx = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] ad_o;
  logic        ad_oe, devsel_n_o, trdy_n_o, ctl_oe;

  int total = 0, bad = 0;
  logic [31:0] sh_regs [NREG];

  // reference model state: 0 idle, 1 skip, 2 turnaround, 3 data, 4 release
  int          m_st = 0, m_idx = 0, m_w = 0, m_wl = 0;
  logic [31:0] m_regs [NREG];

  mux_bus_rd_target dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n(cbe_n),
    .ad_i(ad_i), .wait_cnt(wait_cnt), .ld_valid(ld_valid), .ld_idx(ld_idx),
    .ld_data(ld_data), .ad_o(ad_o), .ad_oe(ad_oe), .devsel_n_o(devsel_n_o),
    .trdy_n_o(trdy_n_o), .ctl_oe(ctl_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_idx = 0; m_w = 0; m_wl = 0;
      for (int i = 0; i < NREG; i++) m_regs[i] = '0;
    end else begin
      case (m_st)
        0: if (!frame_n) begin
             if (cbe_n == 4'b0110 && ad_i[1:0] == 2'b00 && ad_i[31:5] == BASE[31:5]) begin
               m_st = 2; m_idx = int'(ad_i[4:2]); m_wl = int'(wait_cnt);
             end else m_st = 1;
           end
        1: if (frame_n && irdy_n) m_st = 0;
        2: begin m_st = 3; m_w = m_wl; end
        3: if (m_w == 0) begin
             if (!irdy_n) begin
               if (frame_n) m_st = 4;
               else begin m_idx = (m_idx + 1) % NREG; m_w = m_wl; end
             end
           end else m_w = m_w - 1;
        default: m_st = 0;
      endcase
      if (ld_valid) m_regs[ld_idx] = ld_data;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(devsel_n_o == !(m_st == 2 || m_st == 3), "R2", "model devsel_n", 32'(devsel_n_o), 32'(!(m_st == 2 || m_st == 3)));
      chk(ctl_oe == (m_st >= 2), "R10", "model ctl_oe", 32'(ctl_oe), 32'(m_st >= 2));
      chk(ad_oe == (m_st >= 3), "R3", "model ad_oe", 32'(ad_oe), 32'(m_st >= 3));
      // trdy never ahead of the claim (R4), wait clocks per phase
      chk(trdy_n_o == !(m_st == 3 && m_w == 0), "R9", "model trdy_n", 32'(trdy_n_o), 32'(!(m_st == 3 && m_w == 0)));
      if (m_st == 3 && m_w == 0) chk(ad_o == m_regs[m_idx], "R8", "model data", ad_o, m_regs[m_idx]);
    end
  end

  task automatic load(input int idx, input logic [31:0] d);
    @(negedge clk); #1;
    ld_valid = 1'b1; ld_idx = 3'(idx); ld_data = d; sh_regs[idx] = d;
    @(negedge clk); #1;
    ld_valid = 1'b0;
  endtask

  task automatic read_burst(input logic [31:0] addr, input logic [3:0] cmd, input int nw,
                            input int wt, input bit stall, input string dtag);
    bit hit = (cmd == 4'b0110) && (addr[1:0] == 2'b00) && (addr[31:5] == BASE[31:5]);
    int idx = int'(addr[4:2]);
    int left = nw;
    int cyc = 0;
    bit xfer = 1'b0, last_on = 1'b0, held_ok = 1'b0;
    logic [31:0] held = '0;
    @(negedge clk); #1;
    wait_cnt = 4'(wt); frame_n = 1'b0; cbe_n = cmd; ad_i = addr; irdy_n = 1'b1;
    @(negedge clk);
    chk(devsel_n_o == !hit, "R2", "claim after address phase", 32'(devsel_n_o), 32'(!hit));
    chk(ad_oe == 1'b0, "R3", "AD off in turnaround", 32'(ad_oe), 32'd0);
    if (!hit) begin
      #1; ad_i = '0; cbe_n = 4'h0; irdy_n = 1'b0;
      repeat (3) begin
        @(negedge clk);
        chk(devsel_n_o && !ctl_oe, "R2", "unclaimed stays silent", {devsel_n_o, ctl_oe}, 32'd2);
      end
      #1; frame_n = 1'b1;
      @(negedge clk); #1; irdy_n = 1'b1; cbe_n = 4'hF;
      return;
    end
    #1; ad_i = '0; cbe_n = 4'h0;
    forever begin
      if (!last_on) begin
        irdy_n  = (stall && (cyc % 3 == 1)) ? 1'b1 : 1'b0;
        frame_n = (left == 1 && !irdy_n) ? 1'b1 : 1'b0;
        last_on = frame_n;
      end
      xfer = !irdy_n && !trdy_n_o;
      held_ok = !trdy_n_o && irdy_n;
      held = ad_o;
      if (xfer) begin
        chk(ad_o == sh_regs[idx], dtag, "burst word", ad_o, sh_regs[idx]);
        idx = (idx + 1) % NREG;
        left--;
      end
      @(negedge clk);
      cyc++;
      if (cyc == 1 && wt == 0)
        chk(!trdy_n_o && ad_oe, "R5", "first word two clocks after address", {trdy_n_o, ad_oe}, 32'd1);
      if (held_ok)
        chk(!trdy_n_o && ad_o == held, "R7", "data held under initiator stall", ad_o, held);
      if (xfer && left == 0) break;
      chk(ad_oe == 1'b1, "R6", "AD stays enabled", 32'(ad_oe), 32'd1);
      #1;
    end
    chk(ctl_oe && ad_oe && devsel_n_o && trdy_n_o, "R10", "release clock",
        {ctl_oe, ad_oe, devsel_n_o, trdy_n_o}, 32'hF);
    #1; irdy_n = 1'b1; cbe_n = 4'hF;
    @(negedge clk);
    chk(!ctl_oe && !ad_oe, "R10", "drivers off", {ctl_oe, ad_oe}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) sh_regs[i] = '0;
    repeat (3) begin
      @(negedge clk);
      chk(!ad_oe && !ctl_oe && devsel_n_o && trdy_n_o, "R1", "reset outputs",
          {ad_oe, ctl_oe, devsel_n_o, trdy_n_o}, 32'd3);
    end
    #1 rst_n = 1'b1;
    read_burst(BASE + 32'h8, 4'b0110, 1, 0, 1'b0, "R1");
    for (int i = 0; i < NREG; i++) load(i, 32'hA5A5_0000 + 32'(i * 32'h111));
    read_burst(BASE,          4'b0110, 1, 0, 1'b0, "R8");
    read_burst(BASE + 32'h8,  4'b0110, 4, 0, 1'b0, "R8");
    read_burst(BASE + 32'h18, 4'b0110, 5, 2, 1'b0, "R8");
    read_burst(BASE + 32'h4,  4'b0110, 6, 1, 1'b1, "R7");
    read_burst(BASE + 32'h1C, 4'b0110, 3, 3, 1'b1, "R9");
    read_burst(BASE + 32'h4,  4'b0111, 1, 0, 1'b0, "R2");
    read_burst(BASE + 32'h40, 4'b0110, 1, 0, 1'b0, "R2");
    read_burst(BASE + 32'h5,  4'b0110, 1, 0, 1'b0, "R2");
    load(3, 32'hDEAD_BEEF);
    read_burst(BASE + 32'hC,  4'b0110, 2, 0, 1'b0, "R11");
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule